// File: doc/BRIEF.md
# DRAM Error Location to Physical Address Mapper

This block turns the location of a captured DRAM error into the physical byte address it came from. The location arrives as a rank number, a 2-bit bank, a 13-bit row, an 11-bit column and a 2-bit burst count. The burst count is first added into the column. The column, bank and row bits are then moved to physical address positions through a fixed, scattered permutation. That permutation belongs to the 128-bit mode in which DIMMs are fitted as identical pairs.

Each rank owns a 9-bit size, counted in 256 MiB units. The size is loaded through two configuration write strobes: one carries the top bit and one carries the low byte. Ranks are laid out back to back in index order, so a rank's base address is the sum of the sizes of all lower-numbered ranks. A rank whose size is zero holds no memory. A request that names such a rank returns an error flag instead of an address.

Results leave a two-stage pipeline two cycles after the request. Each result carries the full physical address, split also into a page number and an in-page offset. The page size is a parameter. Only the mapping is built here: the memory controller that captures the error location, and all other memory modes, lie outside the block.

Top module: `dram_loc_mapper`

## Requirements
- R1: While reset is asserted and right after it, `outValid` and `outErr` are 0. Every rank's size is zero, so a request issued before any configuration write returns `outErr`=1.
- R2: A rank's size in 256 MiB units is the 9-bit value {hi, lo}. `hi` is `cfgHiBit`, written when `cfgHiWe` is 1. `lo` is `cfgLoByte`, written when `cfgLoWe` is 1. Both writes go to the rank named by `cfgRank`, on the clock edge where the strobe is high.
- R3: The base address of rank k is (sum of the sizes of ranks 0..k-1) × 2^28. Ranks of size zero add nothing to the sum. Rank 0 always has base 0.
- R4: The column used for mapping is (`reqCol` + `reqBurst`) mod 2048. Bit i of that sum (bit 0 = LSB) goes to physical bit 14−i, for i = 0..10.
- R5: `reqBank` bit 0 goes to physical bit 19, and bank bit 1 goes to physical bit 20.
- R6: Row bits go to these physical bits: 0→26, 1→25, 2→24, 3→21, 4→22, 5→23, 6→18, 7→17, 8→16, 9→15, 10→29, 11→28, 12→27.
- R7: `physAddr` is the rank base ORed with the permuted column, bank and row bits. Physical bits 3..0 are always 0.
- R8: `pageOff` is `physAddr[PAGE_BITS-1:0]` and `pageNum` is `physAddr[ADDR_W-1:PAGE_BITS]`. The default PAGE_BITS is 12 (4 KiB pages).
- R9: A request presented with `reqValid`=1 in cycle n produces `outValid`=1 in cycle n+2 and only then. The block accepts one request every cycle, and results come out in request order.
- R10: A request to a rank whose size is zero returns `outValid`=1 and `outErr`=1, with `physAddr`, `pageNum` and `pageOff` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgHiWe | input | 1 | Write strobe for the top size bit of rank `cfgRank` |
| cfgLoWe | input | 1 | Write strobe for the low size byte of rank `cfgRank` |
| cfgRank | input | RANK_W (3) | Rank selected by the configuration writes |
| cfgHiBit | input | 1 | Top bit of the rank size |
| cfgLoByte | input | 8 | Low byte of the rank size |
| reqValid | input | 1 | Request strobe |
| reqRank | input | RANK_W (3) | Rank of the error location |
| reqBank | input | 2 | Bank of the error location |
| reqRow | input | 13 | Row of the error location |
| reqCol | input | 11 | Column of the error location |
| reqBurst | input | 2 | Burst count, added into the column |
| outValid | output | 1 | Result valid |
| outErr | output | 1 | The request hit a rank of size zero |
| physAddr | output | ADDR_W (40) | Physical byte address |
| pageNum | output | ADDR_W-PAGE_BITS (28) | Page number |
| pageOff | output | PAGE_BITS (12) | Offset within the page |

## Verification
The hardest case to reach is a rank base that depends on a size with its top bit set and on sizes stacked across empty ranks between populated ones. The bench loads a table with a gap at rank 1, a 258-unit rank 2 and a lone high rank 7. It then re-sizes rank 1 mid-run, so every higher base must move. Walking single bits through column, bank and row shows each permutation target on its own. A column of 0x7FF with a burst of 1 forces the wraparound to zero. A back-to-back stream that mixes empty and populated ranks shows the exact two-cycle latency with no bubbles.

// File: rtl/addrmap_pkg.sv
package addrmap_pkg;
  // Geometry of the 128-bit identical-pair mode
  localparam int ROW_W      = 13;
  localparam int COL_W      = 11;
  localparam int BANK_W     = 2;
  localparam int BURST_W    = 2;
  localparam int SIZE_LO_W  = 8;
  localparam int SIZE_W     = SIZE_LO_W + 1;
  localparam int UNIT_SHIFT = 28;  // one size unit is 256 MiB
  localparam int FIELD_W    = 30;  // permuted fields occupy bits 29..0

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;  // load stage 1 from the request
    logic finish;   // load stage 2 from stage 1
  } strobe_t;
endpackage

// File: rtl/addrmap_ctrl.sv
module addrmap_ctrl
  import addrmap_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  output strobe_t strb,
  output logic    outValid
);
  logic stage1Valid;
  logic stage2Valid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1Valid <= 1'b0;
      stage2Valid <= 1'b0;
    end else begin
      stage1Valid <= reqValid;
      stage2Valid <= stage1Valid;
    end
  end

  always_comb begin
    strb.capture = reqValid;
    strb.finish  = stage1Valid;
  end

  assign outValid = stage2Valid;
endmodule

// File: rtl/addrmap_dp.sv
module addrmap_dp
  import addrmap_pkg::*;
#(
  parameter int NUM_RANKS = 8,
  parameter int RANK_W    = 3,
  parameter int SUM_W     = 12,
  parameter int ADDR_W    = 40
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgHiWe,
  input  logic                  cfgLoWe,
  input  logic [RANK_W-1:0]     cfgRank,
  input  logic                  cfgHiBit,
  input  logic [SIZE_LO_W-1:0]  cfgLoByte,
  input  strobe_t               strb,
  input  logic [RANK_W-1:0]     reqRank,
  input  logic [BANK_W-1:0]     reqBank,
  input  logic [ROW_W-1:0]      reqRow,
  input  logic [COL_W-1:0]      reqCol,
  input  logic [BURST_W-1:0]    reqBurst,
  output logic [ADDR_W-1:0]     physAddr,
  output logic                  outErr
);
  logic [NUM_RANKS-1:0] sizeHi;
  logic [SIZE_LO_W-1:0] sizeLo  [NUM_RANKS];
  logic [SIZE_W-1:0]    sizeTbl [NUM_RANKS];
  logic [SUM_W-1:0]     baseTbl [NUM_RANKS];
  logic [SUM_W-1:0]     baseAcc;

  // Size table
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sizeHi <= '0;
      for (int r = 0; r < NUM_RANKS; r++) sizeLo[r] <= '0;
    end else begin
      for (int r = 0; r < NUM_RANKS; r++) begin
        if (cfgHiWe && cfgRank == RANK_W'(r)) sizeHi[r] <= cfgHiBit;
        if (cfgLoWe && cfgRank == RANK_W'(r)) sizeLo[r] <= cfgLoByte;
      end
    end
  end

  // Running sum of sizes gives each rank's base
  always_comb begin
    baseAcc = '0;
    for (int r = 0; r < NUM_RANKS; r++) begin
      sizeTbl[r] = {sizeHi[r], sizeLo[r]};
      baseTbl[r] = baseAcc;
      baseAcc    = baseAcc + SUM_W'(sizeTbl[r]);
    end
  end

  // Bit permutation
  logic [COL_W-1:0]   colSum;
  logic [FIELD_W-1:0] fieldBits;

  always_comb begin
    colSum    = reqCol + COL_W'(reqBurst);
    fieldBits = '0;
    for (int i = 0; i < COL_W; i++) fieldBits[14-i] = colSum[i];
    fieldBits[19] = reqBank[0];
    fieldBits[20] = reqBank[1];
    for (int i = 0; i < 3; i++) fieldBits[26-i] = reqRow[i];
    for (int i = 0; i < 3; i++) fieldBits[21+i] = reqRow[3+i];
    for (int i = 0; i < 4; i++) fieldBits[18-i] = reqRow[6+i];
    for (int i = 0; i < 3; i++) fieldBits[29-i] = reqRow[10+i];
  end

  // Stage 1
  logic [FIELD_W-1:0] s1Fields;
  logic [SUM_W-1:0]   s1Base;
  logic               s1Empty;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Fields <= '0;
      s1Base   <= '0;
      s1Empty  <= 1'b0;
    end else if (strb.capture) begin
      s1Fields <= fieldBits;
      s1Base   <= baseTbl[reqRank];
      s1Empty  <= (sizeTbl[reqRank] == '0);
    end
  end

  // Stage 2
  logic [ADDR_W-1:0] s1Addr;
  assign s1Addr = {s1Base, {UNIT_SHIFT{1'b0}}} | ADDR_W'(s1Fields);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      physAddr <= '0;
      outErr   <= 1'b0;
    end else begin
      outErr <= strb.finish & s1Empty;
      if (strb.finish) physAddr <= s1Empty ? '0 : s1Addr;
    end
  end
endmodule

// File: rtl/dram_loc_mapper.sv
module dram_loc_mapper
  import addrmap_pkg::*;
#(
  parameter  int NUM_RANKS = 8,
  parameter  int PAGE_BITS = 12,
  localparam int RANK_W    = $clog2(NUM_RANKS),
  localparam int SUM_W     = SIZE_W + $clog2(NUM_RANKS),
  localparam int ADDR_W    = SUM_W + UNIT_SHIFT
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgHiWe,
  input  logic                  cfgLoWe,
  input  logic [RANK_W-1:0]     cfgRank,
  input  logic                  cfgHiBit,
  input  logic [7:0]            cfgLoByte,
  input  logic                  reqValid,
  input  logic [RANK_W-1:0]     reqRank,
  input  logic [1:0]            reqBank,
  input  logic [12:0]           reqRow,
  input  logic [10:0]           reqCol,
  input  logic [1:0]            reqBurst,
  output logic                  outValid,
  output logic                  outErr,
  output logic [ADDR_W-1:0]     physAddr,
  output logic [ADDR_W-PAGE_BITS-1:0] pageNum,
  output logic [PAGE_BITS-1:0]  pageOff
);
  strobe_t strb;

  addrmap_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .strb     (strb),
    .outValid (outValid)
  );

  addrmap_dp #(
    .NUM_RANKS (NUM_RANKS),
    .RANK_W    (RANK_W),
    .SUM_W     (SUM_W),
    .ADDR_W    (ADDR_W)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cfgHiWe   (cfgHiWe),
    .cfgLoWe   (cfgLoWe),
    .cfgRank   (cfgRank),
    .cfgHiBit  (cfgHiBit),
    .cfgLoByte (cfgLoByte),
    .strb      (strb),
    .reqRank   (reqRank),
    .reqBank   (reqBank),
    .reqRow    (reqRow),
    .reqCol    (reqCol),
    .reqBurst  (reqBurst),
    .physAddr  (physAddr),
    .outErr    (outErr)
  );

  assign pageOff = physAddr[PAGE_BITS-1:0];
  assign pageNum = physAddr[ADDR_W-1:PAGE_BITS];
endmodule

// File: rtl/dram_loc_mapper_chk.sv
module dram_loc_mapper_chk #(
  parameter int RANK_W = 3,
  parameter int ADDR_W = 40
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [RANK_W-1:0] reqRank,
  input logic              outValid,
  input logic              outErr,
  input logic [ADDR_W-1:0] physAddr
);
  logic [1:0] sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  // R1
  always @(posedge clk) begin
    if (!rstN) begin
      reset_quiet_chk: assert (!outValid && !outErr);
    end
  end

  // R9
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd2) |-> (outValid == $past(reqValid, 2)));

  // R10
  empty_rank_chk: assert property (@(posedge clk) disable iff (!rstN)
    outErr |-> (outValid && physAddr == '0));

  // R7
  low_nibble_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outErr) |-> (physAddr[3:0] == 4'd0));

  // R3
  rank0_base_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd2 && outValid && !outErr && $past(reqRank, 2) == '0)
      |-> (physAddr[ADDR_W-1:30] == '0));
endmodule

bind dram_loc_mapper dram_loc_mapper_chk #(
  .RANK_W (RANK_W),
  .ADDR_W (ADDR_W)
) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqRank  (reqRank),
  .outValid (outValid),
  .outErr   (outErr),
  .physAddr (physAddr)
);

// File: tb/test_dram_loc_mapper.sv
module test_dram_loc_mapper;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgHiWe = 1'b0, cfgLoWe = 1'b0;
  logic [2:0]  cfgRank = '0;
  logic        cfgHiBit = 1'b0;
  logic [7:0]  cfgLoByte = '0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqRank = '0;
  logic [1:0]  reqBank = '0;
  logic [12:0] reqRow = '0;
  logic [10:0] reqCol = '0;
  logic [1:0]  reqBurst = '0;
  logic        outValid, outErr;
  logic [39:0] physAddr;
  logic [27:0] pageNum;
  logic [11:0] pageOff;

  int checks = 0;
  int errors = 0;
  logic [8:0] bSize [8];

  always #10 clk = ~clk;

  dram_loc_mapper i_dram_loc_mapper (
    .clk(clk), .rstN(rstN), .cfgHiWe(cfgHiWe), .cfgLoWe(cfgLoWe),
    .cfgRank(cfgRank), .cfgHiBit(cfgHiBit), .cfgLoByte(cfgLoByte),
    .reqValid(reqValid), .reqRank(reqRank), .reqBank(reqBank),
    .reqRow(reqRow), .reqCol(reqCol), .reqBurst(reqBurst),
    .outValid(outValid), .outErr(outErr), .physAddr(physAddr),
    .pageNum(pageNum), .pageOff(pageOff)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Expected address from the mapping rules
  function automatic logic [39:0] expAddr(input int rank, input int bank,
                                          input int row, input int col, input int burst);
    int rowDst [13] = '{26, 25, 24, 21, 22, 23, 18, 17, 16, 15, 29, 28, 27};
    logic [39:0] a = '0;
    logic [39:0] base = '0;
    int c;
    if (bSize[rank] == 0) return '0;
    for (int r = 0; r < rank; r++) base = base + 40'(bSize[r]);
    a = base << 28;
    c = (col + burst) % 2048;
    for (int i = 0; i < 11; i++) if ((c >> i) & 1) a[14-i] = 1'b1;
    if (bank & 1) a[19] = 1'b1;
    if (bank & 2) a[20] = 1'b1;
    for (int i = 0; i < 13; i++) if ((row >> i) & 1) a[rowDst[i]] = 1'b1;
    return a;
  endfunction

  task automatic setSize(input int rank, input logic [8:0] sz);
    @(negedge clk);
    cfgRank = 3'(rank); cfgHiBit = sz[8]; cfgLoByte = sz[7:0];
    cfgHiWe = 1'b1; cfgLoWe = 1'b1;
    @(negedge clk);
    cfgHiWe = 1'b0; cfgLoWe = 1'b0;
    bSize[rank] = sz;
  endtask

  task automatic driveReq(input int rank, input int bank, input int row,
                          input int col, input int burst);
    reqValid = 1'b1; reqRank = 3'(rank); reqBank = 2'(bank);
    reqRow = 13'(row); reqCol = 11'(col); reqBurst = 2'(burst);
  endtask

  task automatic checkOut(input string tag, input int rank, input int bank,
                          input int row, input int col, input int burst);
    logic [39:0] e;
    e = expAddr(rank, bank, row, col, burst);
    chk({tag, " valid"}, 64'(outValid), 64'd1);
    chk({tag, " err"}, 64'(outErr), 64'(bSize[rank] == 0));
    chk({tag, " addr"}, 64'(physAddr), 64'(e));
    chk({tag, " pageNum"}, 64'(pageNum), 64'(e[39:12]));
    chk({tag, " pageOff"}, 64'(pageOff), 64'(e[11:0]));
  endtask

  // One request, with the exact two-cycle latency checked
  task automatic doReq(input string tag, input int rank, input int bank,
                       input int row, input int col, input int burst);
    @(negedge clk);
    driveReq(rank, bank, row, col, burst);
    @(negedge clk);
    reqValid = 1'b0;
    chk({tag, " R9 not early"}, 64'(outValid), 64'd0);
    @(negedge clk);
    checkOut(tag, rank, bank, row, col, burst);
  endtask

  task automatic tReset();
    chk("R1 outValid in reset", 64'(outValid), 64'd0);
    chk("R1 outErr in reset", 64'(outErr), 64'd0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    chk("R1 outValid after reset", 64'(outValid), 64'd0);
    doReq("R1 R10 unconfigured rank0", 0, 1, 5, 7, 0);
  endtask

  task automatic tConfig();
    setSize(0, 9'd1);
    setSize(2, 9'h102);  // R2: top bit set
    setSize(3, 9'd3);
    setSize(7, 9'd5);
  endtask

  task automatic tColumn();
    for (int i = 0; i < 11; i++) doReq($sformatf("R4 col bit %0d", i), 0, 0, 0, 1 << i, 0);
    doReq("R4 burst add", 0, 0, 0, 6, 3);
    doReq("R4 burst wrap", 0, 0, 0, 11'h7FF, 1);
  endtask

  task automatic tBank();
    doReq("R5 bank 1", 0, 1, 0, 0, 0);
    doReq("R5 bank 2", 0, 2, 0, 0, 0);
  endtask

  task automatic tRow();
    for (int i = 0; i < 13; i++) doReq($sformatf("R6 row bit %0d", i), 0, 0, 1 << i, 0, 0);
  endtask

  task automatic tBases();
    doReq("R2 R3 rank2 base", 2, 0, 0, 0, 0);
    doReq("R3 rank3 base", 3, 3, 13'h1FFF, 11'h7FF, 0);
    doReq("R3 rank7 base", 7, 2, 13'h1C00, 5, 2);
    doReq("R7 base ORed with row top", 2, 1, 13'h1C00, 3, 1);
    doReq("R8 page split", 3, 0, 13'h0155, 11'h2AA, 0);
  endtask

  task automatic tEmpty();
    doReq("R10 empty rank1", 1, 3, 13'h1FFF, 11'h7FF, 3);
    doReq("R10 empty rank5", 5, 1, 1, 1, 1);
  endtask

  task automatic tResize();
    setSize(1, 9'd4);
    doReq("R3 rank1 now populated", 1, 0, 0, 0, 0);
    doReq("R3 rank7 shifted", 7, 0, 0, 0, 0);
    setSize(1, 9'd0);
  endtask

  task automatic tStream();
    int rk [6] = '{0, 5, 2, 7, 1, 3};
    int rw [6] = '{1, 2, 4, 8, 16, 32};
    for (int t = 0; t < 8; t++) begin
      @(negedge clk);
      if (t >= 2) checkOut($sformatf("R9 stream %0d", t - 2), rk[t-2], t % 4, rw[t-2], t * 3, t % 4);
      if (t < 6) driveReq(rk[t], (t + 2) % 4, rw[t], (t + 2) * 3, (t + 2) % 4);
      else reqValid = 1'b0;
    end
    @(negedge clk);
    chk("R9 stream drained", 64'(outValid), 64'd0);
  endtask

  initial begin
    for (int r = 0; r < 8; r++) bSize[r] = '0;
    repeat (3) @(negedge clk);
    tReset();
    tConfig();
    tColumn();
    tBank();
    tRow();
    tBases();
    tEmpty();
    tResize();
    tStream();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule